// File: doc/BRIEF.md
# Receive FIFO with Trigger Levels

This block buffers received characters for one serial channel. A serial receiver pushes each character together with three error flags (parity, framing, break). A byte-wide host port pops the oldest character. The byte and its flags stay together in the same entry, so the flags on the host side always describe the byte the host is about to read.

The block keeps a fill count. It compares that count against two trigger levels that are programmed independently. One comparison drives an interrupt request and the other drives a DMA-ready request. A write that arrives when no slot is free is dropped, and a sticky overflow flag records it. The flag clears when the host reads status. A flush input empties the buffer in a single cycle.

Top module: `rx_fifo_trig`

## Requirements
- R1: Reset is synchronous and active high. While it is applied, and on the first cycle after it, `fill_level` is 0 and `ovf_flag`, `irq_req` and `dma_req` are all 0.
- R2: Characters leave in arrival order. `head_byte`, `head_par`, `head_frm` and `head_brk` show the oldest stored entry, and its flags are the ones that were written with that byte.
- R3: `fill_level` counts stored entries from 0 to DEPTH. It changes on the clock edge that accepts a write or a pop. A write and a pop in the same cycle leave it unchanged.
- R4: A write that arrives while `fill_level` equals DEPTH, with no pop in the same cycle, is discarded. The stored entries and `fill_level` stay as they were, and `ovf_flag` reads 1 after that edge.
- R5: `ovf_flag` stays at 1 until a cycle with `stat_rd` high clears it. If a new overflow occurs in the same cycle as `stat_rd`, the flag stays at 1.
- R6: After every edge, `irq_req` is 1 exactly when the new `fill_level` is greater than or equal to the `irq_trig` value sampled at that edge.
- R7: After every edge, `dma_req` is 1 exactly when the new `fill_level` is greater than or equal to the `dma_trig` value sampled at that edge. This comparison is independent of R6.
- R8: `flush` high empties the buffer and clears `ovf_flag` in one cycle. A write or pop in the same cycle has no effect.
- R9: A pop request while the buffer is empty is ignored: `fill_level` stays at 0.
- R10: When the buffer is full, a write in the same cycle as a pop is accepted. `fill_level` stays at DEPTH and no overflow is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Receiver presents a character this cycle |
| wr_byte | input | 8 | Received character |
| wr_par | input | 1 | Parity error flag of the character |
| wr_frm | input | 1 | Framing error flag of the character |
| wr_brk | input | 1 | Break flag of the character |
| pop | input | 1 | Host consumes the head entry |
| flush | input | 1 | Empty the buffer and clear overflow |
| stat_rd | input | 1 | Host status read; clears the overflow flag |
| irq_trig | input | LVL_W | Fill level that raises the interrupt request |
| dma_trig | input | LVL_W | Fill level that raises the DMA-ready request |
| head_byte | output | 8 | Character at the head |
| head_par | output | 1 | Parity flag of the head entry |
| head_frm | output | 1 | Framing flag of the head entry |
| head_brk | output | 1 | Break flag of the head entry |
| fill_level | output | LVL_W | Number of stored entries (0 to DEPTH) |
| ovf_flag | output | 1 | Sticky overflow indication |
| irq_req | output | 1 | Interrupt request: fill level at or above `irq_trig` |
| dma_req | output | 1 | DMA-ready request: fill level at or above `dma_trig` |

## Verification
The bench uses the default DEPTH of 64, so LVL_W is 7. At this size a full buffer and the overflow that follows take only a few dozen cycles to reach. The pointers wrap several times during a run, which exercises the wrap-around of storage. Trigger values of 1, 4, 8 and 64 move the interrupt and DMA requests across both ends of the count range, and the two requests are set apart so that each crosses its threshold on a different edge. Overflow is driven both alone and in the same cycle as a status read, and full-buffer and flush collisions are applied on purpose.

// File: rtl/rx_fifo_pkg.sv
package rx_fifo_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic              brk;
    logic              frm;
    logic              par;
    logic [BYTE_W-1:0] data;
  } rx_entry_t;

  localparam int ENTRY_W = $bits(rx_entry_t);
endpackage

// File: rtl/rx_fifo_store.sv
module rx_fifo_store
  import rx_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [PTR_W-1:0] waddr,
  input  rx_entry_t        wentry,
  input  logic [PTR_W-1:0] raddr,
  output rx_entry_t        rentry
);
  // Simple dual-port array; head read is asynchronous for zero-latency view
  rx_entry_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wentry;
  end

  assign rentry = mem[raddr];
endmodule

// File: rtl/rx_fifo_ctrl.sv
module rx_fifo_ctrl #(
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_valid,
  input  logic             pop,
  input  logic             flush,
  input  logic             stat_rd,
  output logic             wr_fire,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [LVL_W-1:0] level,
  output logic [LVL_W-1:0] level_nxt,
  output logic             ovf
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic full, rd_fire, ovf_evt;

  assign full    = (level == FULL_LVL);
  assign rd_fire = pop && (level != '0) && !flush;
  assign wr_fire = wr_valid && !flush && (!full || rd_fire);
  assign ovf_evt = wr_valid && !flush && full && !rd_fire;

  always_comb begin
    level_nxt = level;
    if (flush)
      level_nxt = '0;
    else if (wr_fire && !rd_fire)
      level_nxt = level + 1'b1;
    else if (rd_fire && !wr_fire)
      level_nxt = level - 1'b1;
  end

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_fire) wr_ptr <= bump(wr_ptr);
      if (rd_fire) rd_ptr <= bump(rd_ptr);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= '0;
      ovf   <= 1'b0;
    end else begin
      level <= level_nxt;
      if (flush)        ovf <= 1'b0;
      else if (ovf_evt) ovf <= 1'b1;
      else if (stat_rd) ovf <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_fifo_thresh.sv
module rx_fifo_thresh #(
  parameter int LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] level_nxt,
  input  logic [LVL_W-1:0] trig,
  output logic             req
);
  // Compare against the next level so the request moves on the same edge as the count
  always_ff @(posedge clk) begin
    if (rst) req <= 1'b0;
    else     req <= (level_nxt >= trig);
  end
endmodule

// File: rtl/rx_fifo_trig.sv
module rx_fifo_trig
  import rx_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_valid,
  input  logic [7:0]       wr_byte,
  input  logic             wr_par,
  input  logic             wr_frm,
  input  logic             wr_brk,
  input  logic             pop,
  input  logic             flush,
  input  logic             stat_rd,
  input  logic [LVL_W-1:0] irq_trig,
  input  logic [LVL_W-1:0] dma_trig,
  output logic [7:0]       head_byte,
  output logic             head_par,
  output logic             head_frm,
  output logic             head_brk,
  output logic [LVL_W-1:0] fill_level,
  output logic             ovf_flag,
  output logic             irq_req,
  output logic             dma_req
);
  logic             wr_fire;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [LVL_W-1:0] level_nxt;
  rx_entry_t        in_entry, head_entry;

  assign in_entry = '{brk: wr_brk, frm: wr_frm, par: wr_par, data: wr_byte};

  rx_fifo_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .pop(pop), .flush(flush),
    .stat_rd(stat_rd), .wr_fire(wr_fire), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .level(fill_level), .level_nxt(level_nxt), .ovf(ovf_flag)
  );

  rx_fifo_store #(.DEPTH(DEPTH)) store_i (
    .clk(clk), .we(wr_fire), .waddr(wr_ptr), .wentry(in_entry),
    .raddr(rd_ptr), .rentry(head_entry)
  );

  // Two independent threshold comparators: index 0 interrupt, index 1 DMA
  logic [1:0][LVL_W-1:0] trig_vec;
  logic [1:0]            req_vec;
  assign trig_vec[0] = irq_trig;
  assign trig_vec[1] = dma_trig;

  for (genvar g = 0; g < 2; g++) begin : g_thresh
    rx_fifo_thresh #(.LVL_W(LVL_W)) th_i (
      .clk(clk), .rst(rst), .level_nxt(level_nxt),
      .trig(trig_vec[g]), .req(req_vec[g])
    );
  end

  assign irq_req   = req_vec[0];
  assign dma_req   = req_vec[1];
  assign head_byte = head_entry.data;
  assign head_par  = head_entry.par;
  assign head_frm  = head_entry.frm;
  assign head_brk  = head_entry.brk;
endmodule

// File: rtl/rx_fifo_trig_chk.sv
module rx_fifo_trig_chk #(
  parameter int DEPTH = 64,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_valid,
  input logic             pop,
  input logic             flush,
  input logic             stat_rd,
  input logic [LVL_W-1:0] irq_trig,
  input logic [LVL_W-1:0] dma_trig,
  input logic [LVL_W-1:0] fill_level,
  input logic             ovf_flag,
  input logic             irq_req,
  input logic             dma_req
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  // R3
  lvl_bound_chk: assert property (@(posedge clk) disable iff (rst)
    fill_level <= FULL_LVL);

  // R4
  ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && fill_level == FULL_LVL && !pop && !flush) |=> ovf_flag);

  // R4
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && fill_level == FULL_LVL && !pop && !flush) |=> fill_level == FULL_LVL);

  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !stat_rd && !flush) |=> ovf_flag);

  // R8
  flush_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (fill_level == '0 && !ovf_flag));

  // R9
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && fill_level == '0 && !wr_valid) |=> fill_level == '0);

  // R10
  full_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && pop && !flush && fill_level == FULL_LVL && !ovf_flag && !stat_rd)
      |=> (fill_level == FULL_LVL && !ovf_flag));

  // R6
  irq_lvl_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq_req == (fill_level >= $past(irq_trig))));

  // R7
  dma_lvl_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (dma_req == (fill_level >= $past(dma_trig))));
endmodule

bind rx_fifo_trig rx_fifo_trig_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst(rst), .wr_valid(wr_valid), .pop(pop), .flush(flush),
  .stat_rd(stat_rd), .irq_trig(irq_trig), .dma_trig(dma_trig),
  .fill_level(fill_level), .ovf_flag(ovf_flag), .irq_req(irq_req),
  .dma_req(dma_req)
);

// File: tb/rx_fifo_trig_tb_top.sv
module rx_fifo_trig_tb_top;
  localparam int DEPTH  = 64;
  localparam int LVL_W  = $clog2(DEPTH + 1);
  localparam int CLK_NS = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_valid = 0, wr_par = 0, wr_frm = 0, wr_brk = 0;
  logic [7:0] wr_byte = '0;
  logic pop = 0, flush = 0, stat_rd = 0;
  logic [LVL_W-1:0] irq_trig = LVL_W'(8), dma_trig = LVL_W'(4);
  logic [7:0] head_byte;
  logic head_par, head_frm, head_brk, ovf_flag, irq_req, dma_req;
  logic [LVL_W-1:0] fill_level;

  always #(CLK_NS/2) clk = ~clk;

  rx_fifo_trig #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_byte(wr_byte),
    .wr_par(wr_par), .wr_frm(wr_frm), .wr_brk(wr_brk), .pop(pop),
    .flush(flush), .stat_rd(stat_rd), .irq_trig(irq_trig), .dma_trig(dma_trig),
    .head_byte(head_byte), .head_par(head_par), .head_frm(head_frm),
    .head_brk(head_brk), .fill_level(fill_level), .ovf_flag(ovf_flag),
    .irq_req(irq_req), .dma_req(dma_req)
  );

  int n_vec = 0;
  int n_bad = 0;
  logic [10:0] sb_q[$];   // {brk, frm, par, byte}
  int m_lvl = 0;
  bit m_ovf = 0;

  task automatic check(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Driver: one cycle of stimulus, model update, and result compare (at negedge)
  task automatic cyc(bit wv, logic [10:0] ent, bit pp, bit fl, bit sr);
    bit rd_fire, ovf_set;
    wr_valid = wv; {wr_brk, wr_frm, wr_par, wr_byte} = ent;
    pop = pp; flush = fl; stat_rd = sr;
    rd_fire = pp && m_lvl > 0 && !fl;
    ovf_set = 0;
    if (fl) begin
      sb_q.delete(); m_lvl = 0;
    end else begin
      if (rd_fire) begin
        // R2: monitor compares head against scoreboard before the pop
        check("R2 head", int'({head_brk, head_frm, head_par, head_byte}), int'(sb_q[0]));
        void'(sb_q.pop_front());
        m_lvl--;
      end
      if (wv) begin
        if (m_lvl < DEPTH) begin sb_q.push_back(ent); m_lvl++; end
        else ovf_set = 1;
      end
    end
    if (fl) m_ovf = 0;
    else if (ovf_set) m_ovf = 1;
    else if (sr) m_ovf = 0;
    @(posedge clk);
    @(negedge clk);
    wr_valid = 0; pop = 0; flush = 0; stat_rd = 0;
    check("R3 level", int'(fill_level), m_lvl);
    check("R5 overflow", int'(ovf_flag), int'(m_ovf));
    check("R6 irq", int'(irq_req), int'(m_lvl >= int'(irq_trig)));
    check("R7 dma", int'(dma_req), int'(m_lvl >= int'(dma_trig)));
  endtask

  function automatic logic [10:0] mk(int i);
    return {i[0] & i[2], i[1], i[0], 8'(i * 37 + 5)};
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: values during reset
    check("R1 level", int'(fill_level), 0);
    check("R1 ovf", int'(ovf_flag), 0);
    rst = 0;
    @(posedge clk); @(negedge clk);
    check("R1 irq", int'(irq_req), 0);
    check("R1 dma", int'(dma_req), 0);

    // R9: pops on empty buffer
    cyc(0, '0, 1, 0, 0);
    cyc(0, '0, 1, 0, 0);

    // R6/R7: fill across both thresholds
    for (int i = 0; i < 10; i++) cyc(1, mk(i), 0, 0, 0);
    // R2: drain a few, then simultaneous write and pop (R3)
    for (int i = 0; i < 5; i++) cyc(0, '0, 1, 0, 0);
    for (int i = 10; i < 14; i++) cyc(1, mk(i), 1, 0, 0);

    // R4: fill to full, then overflow writes
    while (m_lvl < DEPTH) cyc(1, mk(m_lvl + 100), 0, 0, 0);
    cyc(1, 11'h7AA, 0, 0, 0);
    cyc(1, 11'h755, 0, 0, 0);
    // R5: overflow with concurrent status read keeps flag; then plain clear
    cyc(1, 11'h0FF, 0, 0, 1);
    cyc(0, '0, 0, 0, 1);
    check("R5 cleared", int'(ovf_flag), 0);
    // R10: full with write + pop
    cyc(1, 11'h123, 1, 0, 0);
    cyc(1, 11'h321, 1, 0, 0);

    // R6/R7 boundary triggers at the top and bottom of range
    irq_trig = LVL_W'(DEPTH); dma_trig = LVL_W'(1);
    cyc(0, '0, 0, 0, 0);
    // Drain all; R2 order checked throughout including wrapped entries
    while (m_lvl > 0) cyc(0, '0, 1, 0, 0);
    cyc(0, '0, 1, 0, 0);

    // R8: flush with concurrent write and pop, also clears overflow
    for (int i = 0; i < DEPTH; i++) cyc(1, mk(i + 7), 0, 0, 0);
    cyc(1, 11'h001, 0, 0, 0);
    check("R4 ovf set", int'(ovf_flag), 1);
    cyc(1, 11'h002, 1, 1, 0);
    check("R8 flushed", int'(fill_level), 0);
    cyc(1, mk(3), 0, 0, 0);
    cyc(0, '0, 1, 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule